// File: doc/BRIEF.md
# DMA Bus-Handshake Sequencer

This block runs the bus-side handshake for fly-by DMA transfers between a memory and an I/O device on an ISA-style expansion bus. A device raises its request line. The sequencer then asks the CPU for the bus and waits for the grant. While it holds the bus, it runs one or more transfers. Each transfer drives the memory address, acknowledges the device and fires a paired read/write strobe set. The transfer direction picks the strobe pair. The device sees its acknowledge and the memory sees the address, so the data moves in one bus cycle and is never buffered.

The start address and the number of transfers are taken from configuration inputs when a request is accepted. The transfer direction is also taken at that point. Transfers continue back to back while the device keeps requesting and count remains. When the request drops or the count runs out, the bus is handed back. The sequencer then waits for the grant to go away before it accepts the next request. Strobe width is a parameter.

Top module: `dma_handshake_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hold_req, bus_aen, addr_latch, dev_ack, tc, all four strobes are 0 and mem_addr is 0.
- R2: A high dreq seen in idle with cfg_count nonzero raises hold_req in the next cycle; with cfg_count equal to 0 the request is ignored and hold_req stays 0.
- R3: bus_aen and addr_latch rise in the cycle after hold_grant is seen high. They stay high together without a gap for the whole bus tenure, and both fall in the same cycle as hold_req.
- R4: mem_addr carries the transfer address at least one cycle before dev_ack rises. dev_ack is high at least one cycle before the strobes rise. mem_addr does not change while a strobe is high.
- R5: With to_mem=1 (device to memory) a transfer asserts io_rd together with mem_wr. With to_mem=0 it asserts mem_rd together with io_wr. No other strobe combination ever occurs.
- R6: Each strobe pair stays high for exactly STROBE_CLKS consecutive cycles.
- R7: While dreq stays high and count remains, the next transfer follows in the same tenure without dropping hold_req. Its address is the previous address plus one, wrapping modulo 2^ADDR_W.
- R8: The tenure ends, and hold_req falls, after the transfer during which dreq was sampled low at its end, or after the transfer that used up the count.
- R9: tc is high exactly during the strobe cycles of the transfer that exhausts the count, and never otherwise.
- R10: After hold_req falls, it stays low while hold_grant is still high, even if dreq is high.
- R11: to_mem, cfg_addr and cfg_count are sampled only when a request is accepted; changing them during a tenure has no effect on that tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 1 | Device DMA request |
| hold_grant | input | 1 | Bus grant from the CPU |
| to_mem | input | 1 | 1: device to memory, 0: memory to device |
| cfg_addr | input | ADDR_W | First memory address of a tenure |
| cfg_count | input | CNT_W | Transfers allowed in the tenure |
| hold_req | output | 1 | Bus request to the CPU |
| bus_aen | output | 1 | Address-enable on the expansion bus |
| addr_latch | output | 1 | Address latch enable |
| dev_ack | output | 1 | DMA acknowledge to the device |
| mem_addr | output | ADDR_W | Memory address (0 outside a tenure) |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal count, during the last strobe |

## Verification
The bench drops dreq in the middle of a run. A design that checks the request at the wrong point would then run one transfer too many or too few. That mismatch leaves the scoreboard with an item left over or an item missing. A run starting at the top address checks the wrap to zero, which an address that saturates or skips would fail. The bench flips the direction and the configuration inputs during a tenure, which catches a design that reads them live instead of latching them. It also raises the request again while the grant is still high after a release, which shows a sequencer that re-requests too early. A count of zero and a count of one cover the boundaries of the terminal-count and ignore logic.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_ACK,
    S_STROBE,
    S_RECOV,
    S_REL
  } seq_state_t;

  typedef struct packed {
    logic io_rd;
    logic io_wr;
    logic mem_rd;
    logic mem_wr;
  } strobe_set_t;

  // Fly-by pairing: device-to-memory reads the port and writes memory.
  function automatic strobe_set_t pair_strobes(input logic to_mem, input logic on);
    strobe_set_t s;
    s.io_rd  = on &  to_mem;
    s.mem_wr = on &  to_mem;
    s.mem_rd = on & ~to_mem;
    s.io_wr  = on & ~to_mem;
    return s;
  endfunction

  function automatic logic in_tenure(input seq_state_t st);
    return (st == S_ADDR) || (st == S_ACK) || (st == S_STROBE) || (st == S_RECOV);
  endfunction

endpackage

// File: rtl/dmahs_xfer_track.sv
module dmahs_xfer_track #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic [ADDR_W-1:0] addr_q,
  output logic              last_xfer,
  output logic              count_left
);

  logic [CNT_W-1:0] remain_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      addr_q   <= cfg_addr;
      remain_q <= cfg_count;
    end else if (advance) begin
      addr_q   <= step_addr(addr_q);
      remain_q <= step_count(remain_q);
    end
  end

  assign last_xfer  = (remain_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign count_left = (remain_q != '0);

endmodule

// File: rtl/dmahs_strobe_timer.sv
module dmahs_strobe_timer #(
  parameter int STROBE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int TW = (STROBE_CLKS < 2) ? 1 : $clog2(STROBE_CLKS + 1);
  localparam logic [TW-1:0] LAST = TW'(STROBE_CLKS - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + {{(TW-1){1'b0}}, 1'b1};
    else          cnt_q <= '0;
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/dmahs_seq_fsm.sv
module dmahs_seq_fsm
  import dmahs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq,
  input  logic       hold_grant,
  input  logic       cfg_nonzero,
  input  logic       strobe_expire,
  input  logic       count_left,
  output seq_state_t state_q,
  output logic       load,
  output logic       advance
);

  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    unique case (state_q)
      S_IDLE:   if (dreq && cfg_nonzero) begin
                  state_d = S_REQ;
                  load    = 1'b1;
                end
      S_REQ:    if (hold_grant) state_d = S_ADDR;
      S_ADDR:   state_d = S_ACK;
      S_ACK:    state_d = S_STROBE;
      S_STROBE: if (strobe_expire) begin
                  state_d = S_RECOV;
                  advance = 1'b1;
                end
      S_RECOV:  state_d = (dreq && count_left) ? S_ADDR : S_REL;
      S_REL:    if (!hold_grant) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dma_handshake_seq.sv
module dma_handshake_seq
  import dmahs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dreq,
  input  logic              hold_grant,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              hold_req,
  output logic              bus_aen,
  output logic              addr_latch,
  output logic              dev_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              tc
);

  seq_state_t        state_q;
  logic              load, advance, strobe_expire;
  logic              last_xfer, count_left;
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  strobe_set_t       stb;

  // named events for the checker
  logic strobe_on;
  logic tenure_on;

  dmahs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .hold_grant(hold_grant),
    .cfg_nonzero(cfg_count != '0), .strobe_expire(strobe_expire),
    .count_left(count_left), .state_q(state_q), .load(load), .advance(advance)
  );

  dmahs_xfer_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .addr_q(addr_q),
    .last_xfer(last_xfer), .count_left(count_left)
  );

  dmahs_strobe_timer #(.STROBE_CLKS(STROBE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(strobe_on), .expire(strobe_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    dir_q <= 1'b0;
    else if (load) dir_q <= to_mem;
  end

  assign strobe_on  = (state_q == S_STROBE);
  assign tenure_on  = in_tenure(state_q);
  assign stb        = pair_strobes(dir_q, strobe_on);

  assign hold_req   = tenure_on || (state_q == S_REQ);
  assign bus_aen    = tenure_on;
  assign addr_latch = tenure_on;
  assign dev_ack    = (state_q == S_ACK) || strobe_on;
  assign mem_addr   = tenure_on ? addr_q : '0;
  assign io_rd      = stb.io_rd;
  assign io_wr      = stb.io_wr;
  assign mem_rd     = stb.mem_rd;
  assign mem_wr     = stb.mem_wr;
  assign tc         = strobe_on && last_xfer;

endmodule

// File: rtl/dmahs_checker.sv
module dmahs_checker #(
  parameter int ADDR_W      = 16,
  parameter int STROBE_CLKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_req,
  input logic              hold_grant,
  input logic              bus_aen,
  input logic              addr_latch,
  input logic              dev_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              tc,
  input logic              strobe_on
);

  logic any_stb;
  logic hold_q, rel_wait;
  int   width_q;

  assign any_stb = io_rd | io_wr | mem_rd | mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      rel_wait <= 1'b0;
      width_q  <= 0;
    end else begin
      hold_q  <= hold_req;
      width_q <= any_stb ? width_q + 1 : 0;
      if (hold_q && !hold_req) rel_wait <= 1'b1;
      else if (!hold_grant)    rel_wait <= 1'b0;
    end
  end

  a_r5_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> ((io_rd && mem_wr && !mem_rd && !io_wr) ||
                 (mem_rd && io_wr && !io_rd && !mem_wr)));

  a_r4_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_stb) |-> $past(dev_ack));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $stable(mem_addr));

  a_r3_aen_ale: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aen |-> (addr_latch && hold_req));

  a_r3_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> (!bus_aen && !addr_latch));

  a_r9_tc_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (any_stb && strobe_on));

  a_r6_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_stb) |-> (width_q == STROBE_CLKS));

  a_r10_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wait |-> !hold_req);

endmodule

bind dma_handshake_seq dmahs_checker #(.ADDR_W(ADDR_W), .STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_grant(hold_grant),
  .bus_aen(bus_aen), .addr_latch(addr_latch), .dev_ack(dev_ack),
  .mem_addr(mem_addr), .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .tc(tc), .strobe_on(strobe_on)
);

// File: tb/sim_dma_handshake_seq.sv
module sim_dma_handshake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dreq = 1'b0, to_mem = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic hold_grant;
  logic hold_req, bus_aen, addr_latch, dev_ack, io_rd, io_wr, mem_rd, mem_wr, tc;
  logic [AW-1:0] mem_addr;

  int checks = 0, failures = 0, starts = 0, lag = 2, cycles = 0;
  logic [7:0] gpipe;

  typedef struct { logic [AW-1:0] addr; logic dir; logic last; } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_handshake_seq #(.ADDR_W(AW), .CNT_W(CW), .STROBE_CLKS(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .hold_grant(hold_grant), .to_mem(to_mem),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .hold_req(hold_req), .bus_aen(bus_aen),
    .addr_latch(addr_latch), .dev_ack(dev_ack), .mem_addr(mem_addr), .io_rd(io_rd),
    .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc)
  );

  // CPU model: grant follows request after a configurable lag
  always @(posedge clk) begin
    if (!rst_n) gpipe <= '0;
    else        gpipe <= {gpipe[6:0], hold_req};
  end
  assign hold_grant = gpipe[lag-1];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard
  logic p_stb = 0, p_ack = 0, p_hold = 0, p_grant_seen = 0, released = 0, p_aen = 0;
  logic [AW-1:0] p_addr = '0;
  int width = 0;
  item_t cur;
  always @(negedge clk) begin
    logic stb;
    stb = io_rd | io_wr | mem_rd | mem_wr;
    if (rst_n) begin
      if (bus_aen || addr_latch)
        chk(bus_aen && addr_latch && hold_req, "R3 aen/ale/hold together", {bus_aen, addr_latch, hold_req}, 3'b111);
      if (p_grant_seen && p_hold && hold_req)
        chk(bus_aen && addr_latch, "R3 aen after grant", {bus_aen, addr_latch}, 2'b11);
      if (p_hold && !hold_req)
        chk(!bus_aen && !addr_latch, "R3 aen drops with hold", {bus_aen, addr_latch}, 0);
      if (released)
        chk(!hold_req, "R10 hold low while grant high", hold_req, 0);
      if (stb && !p_stb) begin
        starts++;
        width = 1;
        if (sbq.size() == 0) chk(0, "R8 unexpected transfer", mem_addr, 0);
        else begin
          cur = sbq.pop_front();
          chk(mem_addr == cur.addr, "R7 transfer address", mem_addr, cur.addr);
          chk(p_ack && p_aen && p_addr == mem_addr, "R4 address and ack lead strobe",
              {p_ack, p_aen}, 2'b11);
          chk({io_rd, mem_wr, mem_rd, io_wr} == (cur.dir ? 4'b1100 : 4'b0011),
              "R5 R11 strobe pair", {io_rd, mem_wr, mem_rd, io_wr}, cur.dir ? 4'hC : 4'h3);
        end
      end else if (stb) width++;
      if (stb) begin
        chk(tc == cur.last, "R9 tc during strobe", tc, cur.last);
        chk(mem_addr == cur.addr, "R4 address stable in strobe", mem_addr, cur.addr);
      end else
        chk(!tc, "R9 tc outside strobe", tc, 0);
      if (!stb && p_stb) chk(width == SW, "R6 strobe width", width, SW);
      if (p_hold && !hold_req) released = 1;
      else if (!hold_grant) released = 0;
    end
    p_grant_seen = hold_grant;
    p_stb = stb; p_ack = dev_ack; p_hold = hold_req; p_addr = mem_addr; p_aen = bus_aen;
  end

  // Driver: one tenure; dreq dropped after k transfer starts when k < cnt
  task automatic run_tenure(input logic [AW-1:0] a, input int cnt, input logic dir,
                            input int k, input bit scramble);
    int n;
    n = (k < cnt) ? k : cnt;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.addr = a + AW'(i);
      it.dir  = dir;
      it.last = (i == cnt - 1);
      sbq.push_back(it);
    end
    starts = 0;
    @(negedge clk); #1;
    cfg_addr = a; cfg_count = CW'(cnt); to_mem = dir; dreq = 1'b1;
    @(negedge clk); #1;
    chk(hold_req, "R2 hold follows dreq", hold_req, 1);
    if (scramble) begin
      to_mem = ~dir; cfg_addr = 16'h5555; cfg_count = 8'd1;  // R11 ignored mid-tenure
    end
    while (starts < n) begin @(negedge clk); #1; end
    if (k < cnt) dreq = 1'b0;
    while (hold_req) begin @(negedge clk); #1; end
    while (hold_grant) begin @(negedge clk); #1; end   // dreq may stay high here (R10)
    dreq = 1'b0;
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R7 R8 transfer count", sbq.size(), 0);
    sbq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!hold_req && !bus_aen && !addr_latch && !dev_ack && !tc && mem_addr == 0 &&
        !(io_rd | io_wr | mem_rd | mem_wr), "R1 reset state", hold_req, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!hold_req && !bus_aen && !dev_ack && mem_addr == 0, "R1 after reset", hold_req, 0);
    // count zero ignored
    #1 cfg_count = '0; dreq = 1'b1;
    repeat (6) begin @(negedge clk); chk(!hold_req, "R2 zero count ignored", hold_req, 0); end
    #1 dreq = 1'b0;
    run_tenure(16'h1000, 3, 1'b1, 99, 1'b0);   // count-limited, tc on third
    run_tenure(16'h2FFE, 10, 1'b0, 2, 1'b1);   // dreq drop, scrambled config
    lag = 5;
    run_tenure(16'hFFFF, 2, 1'b1, 99, 1'b0);   // wrap, long grant release
    run_tenure(16'h0040, 1, 1'b0, 99, 1'b1);   // single transfer
    lag = 1;
    run_tenure(16'h0100, 4, 1'b1, 3, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule